// File: doc/BRIEF.md
# Remote Restart Power-Sequence Generator

This block turns a request on one of four external restart lines into a staged imitation of a power failure followed by a power recovery, so that a host processor reboots into a chosen loader. Each line is qualified by a hold window: it must stay high for a set number of clock cycles before it counts. The first qualified line is latched as a one-hot source selection. A fixed lowest-index-first priority settles any tie.

A latched selection starts a timed sequence on two active-low outputs. AC-low is asserted alone first. DC-low is then asserted alongside it for a while and released, and a final wait follows with only AC-low held. AC-low is then released and the block drives a fixed restart address, octal 773000, onto the address lines. The sequence ends when the host's reset pulse falls, which clears the selection so that a later request can be taken.

A blind flag covers the whole span from the assertion of AC-low to the release of DC-low. Bus-slave logic uses it to withhold its acknowledge. The selection is also presented to the vector logic. A diagnostic load path sets the selection directly. The flags cannot be read back through any other path. With no request present, host reset pulses cause no activity, which leaves a genuine power failure to the normal traps.

Top module: `restart_seq_top`

## Requirements
- R1: A line counts as qualified only after it has been sampled high on HOLD_CYC consecutive clock edges. A shorter pulse leaves sel_o at zero and both active-low outputs high.
- R2: On the edge where line i qualifies, sel_o becomes the one-hot value with only bit i set, and sel_o never has more than one bit set.
- R3: When several lines qualify on the same edge, the lowest-numbered line is selected.
- R4: bus_ac_lo_n_o goes low on the edge after sel_o becomes nonzero, and stays low with bus_dc_lo_n_o high for AC_CYC cycles.
- R5: bus_dc_lo_n_o is then low for DC_CYC cycles while bus_ac_lo_n_o stays low. It is released, and bus_ac_lo_n_o stays low alone for a further WAIT_CYC cycles.
- R6: On the edge that releases bus_ac_lo_n_o, boot_addr_en_o rises and boot_addr_o carries 18'o773000. While boot_addr_en_o is low, boot_addr_o is zero.
- R7: blind_o is high on exactly the cycles from the first AC-low cycle through the last DC-low cycle.
- R8: During the address phase, on the edge where host_init_i is sampled low after having been high, sel_o clears, boot_addr_en_o drops and the block returns to idle.
- R9: A qualified line or a diagnostic load that arrives while a selection is held or a sequence is running is ignored, and sel_o keeps its value.
- R10: With no request, host_init_i pulses leave both active-low outputs high, blind_o low, boot_addr_en_o low and sel_o zero.
- R11: A diag_load_i pulse while idle loads sel_o with the lowest set bit of diag_val_i, and the sequence of R4 to R6 follows from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Conditioned external restart lines, active high |
| host_init_i | input | 1 | Host reset/INIT pulse, active high |
| diag_load_i | input | 1 | Diagnostic load strobe for the select flags |
| diag_val_i | input | 4 | Value for the diagnostic load |
| bus_ac_lo_n_o | output | 1 | AC-low to the bus, active low |
| bus_dc_lo_n_o | output | 1 | DC-low to the bus, active low |
| blind_o | output | 1 | High while bus reads must not be acknowledged |
| boot_addr_en_o | output | 1 | Drive enable for the restart address |
| boot_addr_o | output | 18 | Restart address, zero when not enabled |
| sel_o | output | 4 | One-hot selected source, to the vector logic |

## Verification
The bench builds the block with HOLD_CYC=8, AC_CYC=6, DC_CYC=6 and WAIT_CYC=8 in place of the millisecond-scale defaults. A full sequence then fits in about thirty cycles, and every phase boundary can be checked on its exact cycle. Runs started from line 0, from line 3, from a tie between lines 1 and 3 and from a diagnostic load each compare every cycle of the sequence against the expected phase table. The short windows also allow competing requests to be injected while a sequence is running.

// File: rtl/restart_seq_pkg.sv
// Package: shared types and constants for the restart sequence generator.
// Assumes: 18-bit bus address space.
package restart_seq_pkg;
    localparam int ADDR_W = 18;
    localparam logic [ADDR_W-1:0] BOOT_ADDR = 18'o773000;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_AC   = 3'd1,
        PH_DC   = 3'd2,
        PH_WAIT = 3'd3,
        PH_ADDR = 3'd4
    } phase_t;
endpackage

// File: rtl/restart_line_filter.sv
// Module: hold-window qualifier for one restart line.
// Emits a single-cycle pulse once the line has been high on HOLD_CYC
// consecutive edges. Assumes the input is already synchronised.
module restart_line_filter #(
    parameter int HOLD_CYC = 450000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic qual_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive high samples, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!req_i)                     cnt_q <= '0;
        else if (cnt_q != CW'(HOLD_CYC))     cnt_q <= cnt_q + 1'b1;
    end

    // Qualification pulse on the edge that completes the window.
    always_comb qual_o = req_i && (cnt_q == CW'(HOLD_CYC - 1));

    // R1: a held line yields only one qualification pulse
    p_single_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |=> !qual_o);
endmodule

// File: rtl/restart_src_capture.sv
// Module: one-hot source selection flags with fixed priority.
// Lowest index wins among qualified lines and diagnostic load bits.
// Loads only when idle and empty; clears on request from the timer.
module restart_src_capture #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] qual_i,
    input  logic         diag_load_i,
    input  logic [N-1:0] diag_val_i,
    input  logic         idle_i,
    input  logic         clr_i,
    output logic [N-1:0] sel_o
);
    logic [N-1:0] cand;
    logic [N-1:0] pick;

    // Merge candidates and keep only the lowest set bit.
    always_comb begin
        cand = qual_i | (diag_load_i ? diag_val_i : '0);
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) pick = N'(1) << i;
        end
    end

    // Select flags: clear on sequence end, load only when free.
    always_ff @(posedge clk) begin
        if (!rst_n)                             sel_o <= '0;
        else if (clr_i)                         sel_o <= '0;
        else if (idle_i && sel_o == '0)         sel_o <= pick;
    end

    // R2: never more than one source selected
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    // R9: a held selection is not replaced by later requests
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != '0 && !clr_i) |=> sel_o == $past(sel_o));
endmodule

// File: rtl/restart_power_timer.sv
// Module: phase sequencer for the emulated power-down/power-up.
// Phases: AC-low alone, AC+DC low, AC-low alone, then address drive
// until the falling edge of host INIT. Assumes each *_CYC >= 1.
module restart_power_timer
    import restart_seq_pkg::*;
#(
    parameter int AC_CYC   = 60000,
    parameter int DC_CYC   = 60000,
    parameter int WAIT_CYC = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic host_init_i,
    output logic ac_lo_n_o,
    output logic dc_lo_n_o,
    output logic blind_o,
    output logic addr_en_o,
    output logic idle_o,
    output logic clr_o
);
    localparam int MAX_AD = (AC_CYC > DC_CYC) ? AC_CYC : DC_CYC;
    localparam int MAX_T  = (MAX_AD > WAIT_CYC) ? MAX_AD : WAIT_CYC;
    localparam int TW     = $clog2(MAX_T + 1);

    phase_t        ph_q;
    logic [TW-1:0] cnt_q;
    logic          init_q;
    logic          init_fall;

    // Remember previous host INIT level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) init_q <= 1'b0;
        else        init_q <= host_init_i;
    end

    always_comb init_fall = init_q && !host_init_i;

    // Phase register and per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) ph_q <= PH_AC;
                end
                PH_AC: begin
                    if (cnt_q == TW'(AC_CYC - 1)) begin
                        ph_q  <= PH_DC;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_DC: begin
                    if (cnt_q == TW'(DC_CYC - 1)) begin
                        ph_q  <= PH_WAIT;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_WAIT: begin
                    if (cnt_q == TW'(WAIT_CYC - 1)) begin
                        ph_q  <= PH_ADDR;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_ADDR: begin
                    if (init_fall) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Output decode from the phase register.
    always_comb begin
        ac_lo_n_o = !(ph_q == PH_AC || ph_q == PH_DC || ph_q == PH_WAIT);
        dc_lo_n_o = (ph_q != PH_DC);
        blind_o   = (ph_q == PH_AC || ph_q == PH_DC);
        addr_en_o = (ph_q == PH_ADDR);
        idle_o    = (ph_q == PH_IDLE);
        clr_o     = (ph_q == PH_ADDR) && init_fall;
    end

    // R5: DC-low only ever appears inside an AC-low window
    p_dc_in_ac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_lo_n_o |-> !ac_lo_n_o);
    // R6: address drive starts right after AC-low is released
    p_addr_after_ac_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_en_o) |-> ($past(!ac_lo_n_o) && ac_lo_n_o));
endmodule

// File: rtl/restart_seq_top.sv
// Module: remote restart power-sequence generator, top level.
// Four qualified restart lines select a source; a selection drives the
// AC-low / DC-low sequence and then the fixed restart address.
// Assumes req_i is conditioned and synchronous to clk.
module restart_seq_top
    import restart_seq_pkg::*;
#(
    parameter int N_LINES  = 4,
    parameter int HOLD_CYC = 450000,
    parameter int AC_CYC   = 60000,
    parameter int DC_CYC   = 60000,
    parameter int WAIT_CYC = 80000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  req_i,
    input  logic                host_init_i,
    input  logic                diag_load_i,
    input  logic [N_LINES-1:0]  diag_val_i,
    output logic                bus_ac_lo_n_o,
    output logic                bus_dc_lo_n_o,
    output logic                blind_o,
    output logic                boot_addr_en_o,
    output logic [ADDR_W-1:0]   boot_addr_o,
    output logic [N_LINES-1:0]  sel_o
);
    logic [N_LINES-1:0] qual;
    logic               idle;
    logic               clr;

    // One hold-window qualifier per restart line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        restart_line_filter #(.HOLD_CYC(HOLD_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[g]),
            .qual_o (qual[g])
        );
    end

    restart_src_capture #(.N(N_LINES)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual_i      (qual),
        .diag_load_i (diag_load_i),
        .diag_val_i  (diag_val_i),
        .idle_i      (idle),
        .clr_i       (clr),
        .sel_o       (sel_o)
    );

    restart_power_timer #(
        .AC_CYC   (AC_CYC),
        .DC_CYC   (DC_CYC),
        .WAIT_CYC (WAIT_CYC)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (sel_o != '0),
        .host_init_i (host_init_i),
        .ac_lo_n_o   (bus_ac_lo_n_o),
        .dc_lo_n_o   (bus_dc_lo_n_o),
        .blind_o     (blind_o),
        .addr_en_o   (boot_addr_en_o),
        .idle_o      (idle),
        .clr_o       (clr)
    );

    // Restart address gated by the drive enable.
    always_comb boot_addr_o = boot_addr_en_o ? BOOT_ADDR : '0;

    // R4: AC-low only starts from a held selection
    p_ac_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ac_lo_n_o) |-> $past(sel_o != '0));
    // R7: blind covers every DC-low cycle
    p_blind_dc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dc_lo_n_o |-> blind_o);
    // R10: no bus activity without a selection
    p_passive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0) |-> (bus_ac_lo_n_o && bus_dc_lo_n_o && !boot_addr_en_o));
endmodule

// File: tb/restart_seq_top_tb_top.sv
// Bench: directed scenarios for restart_seq_top with short phase windows.
module restart_seq_top_tb_top;
    localparam int HOLD = 8;
    localparam int TAC  = 6;
    localparam int TDC  = 6;
    localparam int TWT  = 8;
    localparam logic [17:0] ADDR_EXP = 18'o773000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_i = '0;
    logic        host_init_i = 1'b0;
    logic        diag_load_i = 1'b0;
    logic [3:0]  diag_val_i = '0;
    logic        bus_ac_lo_n_o, bus_dc_lo_n_o, blind_o, boot_addr_en_o;
    logic [17:0] boot_addr_o;
    logic [3:0]  sel_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    restart_seq_top #(
        .N_LINES(4), .HOLD_CYC(HOLD), .AC_CYC(TAC), .DC_CYC(TDC), .WAIT_CYC(TWT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .host_init_i(host_init_i),
        .diag_load_i(diag_load_i), .diag_val_i(diag_val_i),
        .bus_ac_lo_n_o(bus_ac_lo_n_o), .bus_dc_lo_n_o(bus_dc_lo_n_o),
        .blind_o(blind_o), .boot_addr_en_o(boot_addr_en_o),
        .boot_addr_o(boot_addr_o), .sel_o(sel_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Run one sequence; base = negedge index at which sel_o is expected set.
    task automatic run_seq(input logic [3:0] sel_exp, input int base,
                           input bit inject, input string tag);
        int e_sel = 0, e_ac = 0, e_dc = 0, e_bl = 0, e_ad = 0, e_inj = 0;
        for (int k = 1; k <= base + 24; k++) begin
            @(negedge clk);
            if (sel_o !== ((k >= base) ? sel_exp : 4'b0)) e_sel++;
            if (bus_ac_lo_n_o !== !(k >= base + 1 && k <= base + 20)) e_ac++;
            if (bus_dc_lo_n_o !== !(k >= base + 7 && k <= base + 12)) e_dc++;
            if (blind_o !== (k >= base + 1 && k <= base + 12)) e_bl++;
            if (boot_addr_en_o !== (k >= base + 21)) e_ad++;
            if (boot_addr_o !== ((k >= base + 21) ? ADDR_EXP : 18'd0)) e_ad++;
            if (inject && k > base && sel_o !== sel_exp && k < base + 21) e_inj++;
            if (k == 1) diag_load_i = 1'b0;
            if (k == base + 1) req_i = '0;
            if (inject && k == base + 3) req_i = (sel_exp == 4'b0001) ? 4'b1000 : 4'b0001;
            if (inject && k == base + 4) begin
                diag_load_i = 1'b1;
                diag_val_i  = 4'b0100;
            end
            if (inject && k == base + 5) diag_load_i = 1'b0;
            if (inject && k == base + 14) req_i = '0;
        end
        chk(e_sel == 0, {tag, " R2 selection value/timing"}, e_sel, 0);
        chk(e_ac == 0, {tag, " R4 AC-low window"}, e_ac, 0);
        chk(e_dc == 0, {tag, " R5 DC-low window"}, e_dc, 0);
        chk(e_bl == 0, {tag, " R7 blind window"}, e_bl, 0);
        chk(e_ad == 0, {tag, " R6 address drive"}, e_ad, 0);
        if (inject) chk(e_inj == 0, {tag, " R9 busy requests ignored"}, e_inj, 0);
        // End the sequence with a host INIT pulse.
        host_init_i = 1'b1;
        @(negedge clk);
        host_init_i = 1'b0;
        chk(boot_addr_en_o === 1'b1, {tag, " R8 address held until INIT falls"},
            boot_addr_en_o, 1);
        @(negedge clk);
        chk(sel_o === 4'b0 && boot_addr_en_o === 1'b0 && bus_ac_lo_n_o === 1'b1,
            {tag, " R8 cleared on INIT fall"}, {sel_o, 3'b0, boot_addr_en_o}, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(sel_o === 4'b0 && bus_ac_lo_n_o && bus_dc_lo_n_o && !blind_o
            && !boot_addr_en_o && boot_addr_o === 18'd0,
            "R10 reset state", {sel_o, bus_ac_lo_n_o, bus_dc_lo_n_o, blind_o}, 32'h6);
    endtask

    task automatic t_short_pulse();
        int e = 0;
        req_i = 4'b0001;
        repeat (HOLD - 1) @(negedge clk);
        req_i = '0;
        repeat (20) begin
            @(negedge clk);
            if (sel_o !== 4'b0 || bus_ac_lo_n_o !== 1'b1 || bus_dc_lo_n_o !== 1'b1) e++;
        end
        chk(e == 0, "R1 short pulse rejected", e, 0);
    endtask

    task automatic t_line0();
        req_i = 4'b0001;
        run_seq(4'b0001, HOLD, 1'b0, "line0");
    endtask

    task automatic t_line3_busy();
        req_i = 4'b1000;
        run_seq(4'b1000, HOLD, 1'b1, "line3");
    endtask

    task automatic t_priority();
        req_i = 4'b1010;
        run_seq(4'b0010, HOLD, 1'b0, "R3 tie lines1+3");
    endtask

    task automatic t_diag();
        diag_val_i  = 4'b1100;
        diag_load_i = 1'b1;
        run_seq(4'b0100, 1, 1'b0, "R11 diag load");
    endtask

    task automatic t_passive();
        int e = 0;
        for (int p = 0; p < 4; p++) begin
            host_init_i = 1'b1;
            @(negedge clk);
            host_init_i = 1'b0;
            repeat (4) begin
                @(negedge clk);
                if (sel_o !== 4'b0 || !bus_ac_lo_n_o || !bus_dc_lo_n_o || blind_o
                    || boot_addr_en_o) e++;
            end
        end
        chk(e == 0, "R10 INIT without request is passive", e, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_pulse();
        t_line0();
        t_line3_busy();
        t_priority();
        t_diag();
        t_passive();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule